// File: doc/BRIEF.md
# Hit Sample Capture and Serial Dump Controller

This block records the per-channel hit bits of a strip readout front end during a measurement window and later dumps the full record through a serial link. The hit samples come in as two half-rate streams: stream A holds the even-numbered samples and stream B the odd-numbered samples, one bit per channel each cycle. A capture strobe starts a fill. Every cycle, one sample from each stream is stored. The fill ends by itself once all `DEPTH` sample addresses hold data. With the default depth of 8192 and a 5 ns sample interval, this is a 40.96 µs window.

A dump strobe sends out the whole memory. Every cycle, the serial port presents two bits, one for the rising half and one for the falling half of the link clock. This gives a double-data-rate stream at the link clock rate. Each strobe is ignored while the other operation is running. When the last bit has left, a one-cycle done pulse is raised. The block then returns to idle with its counters rewound, ready for the next fill or another dump of the same data.

Top module: `hitmem_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, `wr_busy_o`, `rd_busy_o`, `ser_valid_o` and `done_o` are 0.
- R2: If `wr_start_i` is high at a clock edge while idle, `wr_busy_o` is 1 after that edge. At each of the next DEPTH/2 edges, `hit_a_i` is stored as sample address 2k and `hit_b_i` as sample address 2k+1, with k counting from 0.
- R3: A fill stops by itself after DEPTH/2 stores: `wr_busy_o` is high for exactly DEPTH/2 cycles.
- R4: If `rd_start_i` is high at an edge while idle, `rd_busy_o` is 1 after that edge. The first bit pair appears with `ser_valid_o`=1 after the second following edge. After that, one pair appears per cycle, with no gaps, for DEPTH*NCH/2 cycles.
- R5: The dump order is sample address 0 upward. Within one address, channels go from 0 upward. `ser_rise_o` carries the even channel 2p and `ser_fall_o` carries channel 2p+1, and the rise bit comes first on the link.
- R6: `rd_start_i` has no effect while a fill is running. No dump follows, and `rd_busy_o` and `ser_valid_o` stay 0.
- R7: `wr_start_i` has no effect while a dump is running. The stream in progress and the stored data are both unchanged.
- R8: `done_o` is high for exactly the cycle that carries the last bit pair. Afterwards `rd_busy_o` is 0, and a second dump repeats the same stream.
- R9: If both strobes are high at the same edge while idle, the fill wins and the dump strobe is dropped.
- R10: A new fill overwrites every stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_a_i | input | NCH | Even-sample hit bits, one per channel |
| hit_b_i | input | NCH | Odd-sample hit bits, one per channel |
| wr_start_i | input | 1 | Capture strobe |
| rd_start_i | input | 1 | Dump strobe |
| wr_busy_o | output | 1 | Fill in progress |
| rd_busy_o | output | 1 | Dump in progress |
| ser_rise_o | output | 1 | Serial bit for the rising half of the link clock |
| ser_fall_o | output | 1 | Serial bit for the falling half of the link clock |
| ser_valid_o | output | 1 | Serial pair is valid |
| done_o | output | 1 | One-cycle pulse with the last pair |

## Verification
The schedule is fixed. A strobe sampled at edge E0 raises the busy flag after E0. A fill stores data at edges E1 through E(DEPTH/2). A dump shows its first pair after E2 and its last pair, together with `done_o`, after E(1+DEPTH*NCH/2).

The bench drives inputs on falling edges and samples outputs on the falling edge after each of these rising edges. Every pair is compared with an expected stream built from the bench's own record of what it wrote. A small configuration (16 addresses, 4 channels) is used so that every address and channel is compared on every dump.

// File: rtl/hitmem_pkg.sv
package hitmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_PRIME = 2'd2,
    ST_READ  = 2'd3
  } hm_state_e;
endpackage

// File: rtl/hitmem_bank.sv
module hitmem_bank #(
  parameter int ROWS = 4096,
  parameter int W    = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [RW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/hitmem_seq.sv
module hitmem_seq
  import hitmem_pkg::*;
#(
  parameter int DEPTH = 8192,
  parameter int NCH   = 8,
  localparam int ROWS = DEPTH / 2,
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = $clog2(DEPTH),
  localparam int NP   = NCH / 2,
  localparam int PW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_start_i,
  input  logic          rd_start_i,
  output hm_state_e     state_o,
  output logic          we_o,
  output logic [RW-1:0] wr_row_o,
  output logic [RW-1:0] rd_row_o,
  output logic          addr_lsb_o,
  output logic [PW-1:0] pair_o,
  output logic          last_o
);
  localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [PW-1:0] LAST_PAIR = PW'(NP - 1);

  hm_state_e     state_q;
  logic [RW-1:0] wr_row_q;
  logic [AW-1:0] addr_q, addr_nxt;
  logic [PW-1:0] pair_q;
  logic          pair_end;

  assign pair_end = (pair_q == LAST_PAIR);
  assign addr_nxt = addr_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_row_q <= '0;
      addr_q   <= '0;
      pair_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_start_i) begin
            state_q  <= ST_WRITE;
            wr_row_q <= '0;
          end else if (rd_start_i) begin
            state_q <= ST_PRIME;
            addr_q  <= '0;
            pair_q  <= '0;
          end
        end
        ST_WRITE: begin
          wr_row_q <= wr_row_q + RW'(1);
          if (wr_row_q == LAST_ROW) state_q <= ST_IDLE;
        end
        ST_PRIME: state_q <= ST_READ;
        ST_READ: begin
          if (pair_end) begin
            pair_q <= '0;
            addr_q <= addr_nxt;
            if (addr_q == LAST_ADDR) state_q <= ST_IDLE;
          end else begin
            pair_q <= pair_q + PW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // fetch the next address during the last pair so the dump has no gaps
  assign rd_row_o   = (state_q == ST_READ && pair_end) ? addr_nxt[AW-1:1] : addr_q[AW-1:1];
  assign state_o    = state_q;
  assign we_o       = (state_q == ST_WRITE);
  assign wr_row_o   = wr_row_q;
  assign addr_lsb_o = addr_q[0];
  assign pair_o     = pair_q;
  assign last_o     = (state_q == ST_READ) && pair_end && (addr_q == LAST_ADDR);

  assert_wr_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE && wr_row_q == LAST_ROW) |=> state_q == ST_IDLE);
  assert_rd_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE && rd_start_i) |=> (state_q == ST_WRITE || state_q == ST_IDLE));
  assert_wr_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_READ || state_q == ST_PRIME) && wr_start_i) |=> state_q != ST_WRITE);
  assert_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && wr_start_i && rd_start_i) |=> state_q == ST_WRITE);
  assert_prime_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRIME) |=> (state_q == ST_READ && pair_q == '0));
endmodule

// File: rtl/hitmem_ser.sv
module hitmem_ser #(
  parameter int NCH  = 8,
  localparam int NP  = NCH / 2,
  localparam int PW  = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_i,
  input  logic           addr_lsb_i,
  input  logic [PW-1:0]  pair_i,
  input  logic           last_i,
  input  logic [NCH-1:0] rdata_e_i,
  input  logic [NCH-1:0] rdata_o_i,
  output logic           ser_rise_o,
  output logic           ser_fall_o,
  output logic           ser_valid_o,
  output logic           done_o
);
  logic [NCH-1:0] hold_q, word, cur, sh;

  assign word = addr_lsb_i ? rdata_o_i : rdata_e_i;
  assign cur  = (pair_i == '0) ? word : hold_q;
  assign sh   = cur >> {pair_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      ser_rise_o  <= 1'b0;
      ser_fall_o  <= 1'b0;
      ser_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      if (rd_i && pair_i == '0) hold_q <= word;
      ser_valid_o <= rd_i;
      ser_rise_o  <= rd_i & sh[0];
      ser_fall_o  <= rd_i & sh[1];
      done_o      <= last_i;
    end
  end

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/hitmem_ctrl.sv
module hitmem_ctrl
  import hitmem_pkg::*;
#(
  parameter int DEPTH = 8192,
  parameter int NCH   = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_a_i,
  input  logic [NCH-1:0] hit_b_i,
  input  logic           wr_start_i,
  input  logic           rd_start_i,
  output logic           wr_busy_o,
  output logic           rd_busy_o,
  output logic           ser_rise_o,
  output logic           ser_fall_o,
  output logic           ser_valid_o,
  output logic           done_o
);
  localparam int ROWS = DEPTH / 2;
  localparam int RW   = $clog2(ROWS);
  localparam int NP   = NCH / 2;
  localparam int PW   = (NP > 1) ? $clog2(NP) : 1;

  hm_state_e      state;
  logic           we, addr_lsb, last;
  logic [RW-1:0]  wr_row, rd_row;
  logic [PW-1:0]  pair;
  logic [NCH-1:0] rdata [2];

  hitmem_seq #(.DEPTH(DEPTH), .NCH(NCH)) u_seq (
    .clk_i, .rst_ni, .wr_start_i, .rd_start_i,
    .state_o(state), .we_o(we), .wr_row_o(wr_row), .rd_row_o(rd_row),
    .addr_lsb_o(addr_lsb), .pair_o(pair), .last_o(last)
  );

  // bank 0 holds even sample addresses, bank 1 odd ones
  for (genvar g = 0; g < 2; g++) begin : g_bank
    hitmem_bank #(.ROWS(ROWS), .W(NCH)) u_bank (
      .clk_i, .we_i(we), .waddr_i(wr_row),
      .wdata_i((g == 0) ? hit_a_i : hit_b_i),
      .raddr_i(rd_row), .rdata_o(rdata[g])
    );
  end

  hitmem_ser #(.NCH(NCH)) u_ser (
    .clk_i, .rst_ni, .rd_i(state == ST_READ), .addr_lsb_i(addr_lsb),
    .pair_i(pair), .last_i(last), .rdata_e_i(rdata[0]), .rdata_o_i(rdata[1]),
    .ser_rise_o, .ser_fall_o, .ser_valid_o, .done_o
  );

  assign wr_busy_o = (state == ST_WRITE);
  assign rd_busy_o = (state == ST_PRIME) || (state == ST_READ);

  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ser_valid_o && !rd_busy_o));
  assert_valid_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_valid_o) |-> $past(rd_busy_o, 2));
  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_o |-> !ser_valid_o);
endmodule

// File: tb/hitmem_ctrl_test.sv
module hitmem_ctrl_test;
  localparam int DEPTH = 16;
  localparam int NCH   = 4;
  localparam int ROWS  = DEPTH / 2;
  localparam int NPAIR = DEPTH * NCH / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] hit_a = '0, hit_b = '0;
  logic wr_start = 1'b0, rd_start = 1'b0;
  logic wr_busy, rd_busy, ser_rise, ser_fall, ser_valid, done;

  int total = 0, fails = 0;
  bit finished = 1'b0;
  logic [NCH-1:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  hitmem_ctrl #(.DEPTH(DEPTH), .NCH(NCH)) uut (
    .clk_i(clk), .rst_ni, .hit_a_i(hit_a), .hit_b_i(hit_b),
    .wr_start_i(wr_start), .rd_start_i(rd_start),
    .wr_busy_o(wr_busy), .rd_busy_o(rd_busy), .ser_rise_o(ser_rise),
    .ser_fall_o(ser_fall), .ser_valid_o(ser_valid), .done_o(done)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [NCH-1:0] patt(int seed, int a);
    if (seed == 0) return '0;
    if (seed == 1) return '1;
    return NCH'((seed * 5 + a * 11 + (a >> 1)) ^ (a << (seed % 3)));
  endfunction

  task automatic do_write(int seed, bit poke, bit both);
    int busy_cnt = 0;
    @(negedge clk);
    wr_start = 1'b1;
    rd_start = both;
    @(posedge clk);
    @(negedge clk);
    wr_start = 1'b0;
    rd_start = 1'b0;
    chk(wr_busy == 1'b1, "R2 wr_busy after start", wr_busy, 1);
    if (both) chk(rd_busy == 1'b0, "R9 dump dropped", rd_busy, 0);
    for (int k = 0; k < ROWS; k++) begin
      hit_a = patt(seed, 2 * k);
      hit_b = patt(seed, 2 * k + 1);
      rd_start = poke && (k == 1);
      if (wr_busy) busy_cnt++;
      @(posedge clk);
      @(negedge clk);
    end
    rd_start = 1'b0;
    hit_a = '1;
    hit_b = '0;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = patt(seed, a);
    chk(busy_cnt == ROWS, "R3 busy cycles", busy_cnt, ROWS);
    chk(wr_busy == 1'b0, "R3 fill stopped", wr_busy, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rd_busy == 1'b0, "R6 no dump after ignored strobe", rd_busy, 0);
    chk(ser_valid == 1'b0, "R6 no serial output", ser_valid, 0);
  endtask

  task automatic do_read(bit inject);
    @(negedge clk);
    rd_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_start = 1'b0;
    chk(rd_busy == 1'b1, "R4 rd_busy after start", rd_busy, 1);
    chk(ser_valid == 1'b0, "R4 no pair yet (E0)", ser_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R4 no pair yet (E1)", ser_valid, 0);
    for (int i = 0; i < NPAIR; i++) begin
      wr_start = inject && (i == 3);
      hit_a = NCH'(i);
      hit_b = ~NCH'(i);
      @(posedge clk);
      @(negedge clk);
      begin
        int a = (2 * i) / NCH;
        int c = (2 * i) % NCH;
        chk(ser_valid == 1'b1, "R4 pair valid", ser_valid, 1);
        chk(ser_rise == exp_mem[a][c], "R5 rise bit", ser_rise, int'(exp_mem[a][c]));
        chk(ser_fall == exp_mem[a][c+1], "R5 fall bit", ser_fall, int'(exp_mem[a][c+1]));
        chk(done == (i == NPAIR - 1), "R8 done timing", done, int'(i == NPAIR - 1));
      end
    end
    wr_start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R4 stream ended", ser_valid, 0);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(rd_busy == 1'b0, "R8 idle after dump", rd_busy, 0);
    chk(wr_busy == 1'b0, "R7 no fill from ignored strobe", wr_busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wr_busy && !rd_busy && !ser_valid && !done, "R1 reset state",
        {wr_busy, rd_busy, ser_valid, done}, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!wr_busy && !rd_busy && !ser_valid && !done, "R1 after release",
        {wr_busy, rd_busy, ser_valid, done}, 0);

    do_write(2, 1'b0, 1'b0);   // R2 basic fill
    do_read(1'b0);
    do_read(1'b0);             // R8 repeat dump
    do_write(0, 1'b1, 1'b0);   // R10 overwrite with zeros, R6 poke
    do_read(1'b0);
    do_write(1, 1'b0, 1'b1);   // R9 both strobes, all ones
    do_read(1'b1);             // R7 strobe during dump
    do_read(1'b0);             // R7 data untouched
    for (int s = 3; s < 7; s++) begin
      do_write(s, 1'b0, 1'b0);
      do_read(1'b0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule